// File: doc/BRIEF.md
# Soft-Mute Gain Ramp and Interrupt Flag Unit

This block is the digital control side of a soft mute for two audio outputs: the DAC path and the headphone path. Each path holds a 5-bit gain code. Code 0 is full attenuation (muted) and code 31 is full level. When software changes a path's mute bit, the code walks toward its new target by one code every `STEP_CYC` clock cycles. When the code arrives, the path raises a flag that names the direction of the move. If the path is in standby, the code jumps straight to its target and no flag is raised.

The flags live in a sticky register. Software clears a flag by writing 1 to its bit. A mask register keeps chosen flags off the single interrupt line. A 2-bit form field picks how that line signals: as a level or as a one-cycle pulse, and active high or active low. A jack-detect input is synchronised inside the block, and either of its edges sets the jack flag.

Writes come over a simple internal register bus (`reg_wr`, `reg_addr`, `reg_wdata`). A combinational read port (`reg_raddr`, `reg_rdata`) returns the register contents.

Each path is controlled by one state machine with three states:
- HOLD: the code is at rest.
- RISE: the code steps toward 31.
- FALL: the code steps toward 0.

Its transitions are:
- HOLD to RISE: the code is below its target, standby is clear and the path is unmuted.
- HOLD to FALL: the code is above its target, standby is clear and the path is muted.
- RISE to HOLD: the step that reaches 31 (the up flag is set), or the mute bit becomes set while rising.
- FALL to HOLD: the step that reaches 0 (the down flag is set), or the mute bit becomes clear while falling.
- Any state to HOLD: standby is set. The code is forced to its target in the same step.

After a reversal, the HOLD state starts the opposite ramp on the next cycle, from the current code.

Top module: `soft_mute_irq`

## Requirements
- R1: After reset the register addresses and their reset values are:
  - 0 (DAC control): 0x90.
  - 1 (headphone control): 0x90.
  - 2 (flags): 0x00.
  - 3 (mask): 0x7F.
  - 4 (interrupt control): 0x00.
  In both control registers, bit 7 is mute and bit 4 is standby. Both gain codes are 0 and `irq` is low after reset.
- R2: With standby clear, clearing a path's mute bit moves its gain code up by exactly one code per step to 31. Setting the mute bit moves it down by one code per step to 0. Every intermediate code appears in order.
- R3: The DAC path sets flag bit 1 when its code reaches 31 and flag bit 0 when its code reaches 0. The flag is set on the same clock edge on which the code takes its final value, and not before.
- R4: The headphone path sets flag bit 3 when its code reaches 31 and flag bit 2 when its code reaches 0.
- R5: A mute change in the middle of a ramp reverses the ramp from the current code. The abandoned direction raises no flag.
- R6: While a path's standby bit is set, a mute change moves the code directly to 0 or 31 in one step and raises no flag.
- R7: Writing to the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0x7F clears every flag. Bits 6 (short-circuit clear) and 4 (short-circuit) have no source in this block and read 0.
- R8: Either edge of `jack_in`, after a two-stage synchroniser, sets flag bit 5.
- R9: A mask bit of 1 keeps the flag in the same position off `irq`, while the flag is still recorded in the flag register.
- R10: Interrupt control bits 7:6 select the form of `irq`:
  - 0: active-high level while any unmasked flag is set.
  - 1: active-low level while any unmasked flag is set.
  - 2: a one-cycle high pulse for each newly set unmasked flag.
  - 3: a one-cycle low pulse for each newly set unmasked flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| jack_in | input | 1 | Asynchronous jack-detect level |
| dac_gain | output | 5 | DAC path gain code, 31 = full level |
| hp_gain | output | 5 | Headphone path gain code, 31 = full level |
| irq | output | 1 | Interrupt line, form set by interrupt control |

## Verification
A ramp state machine in the wrong state shows up at the next gain-code change, at the latest `STEP_CYC` cycles later. It appears as a skipped code, a repeated direction or a jump, and the bench compares every change against an expected sequence queued by the driver. A wrong completion flag, a flag set one step early, or a flag cleared by a 0 bit is visible on the read port on the same cycle in which the final code appears. A wrong mask or form decode shows on `irq` in the cycle after the flag or control write. Pulse forms are judged by counting exactly one active cycle per jack edge.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 8;
    localparam int FLAG_W     = 7;

    localparam logic [REG_ADDR_W-1:0] ADR_DAC_CTL = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_HP_CTL  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_FLAGS   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_MASK    = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADR_ICTL    = 3'd4;

    localparam int CTL_MUTE_BIT = 7;
    localparam int CTL_SB_BIT   = 4;

    localparam int FB_SC_CLR  = 6;
    localparam int FB_JACK    = 5;
    localparam int FB_SC      = 4;
    localparam int FB_HP_UP   = 3;
    localparam int FB_HP_DN   = 2;
    localparam int FB_DAC_UP  = 1;
    localparam int FB_DAC_DN  = 0;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_RISE = 2'd1,
        RAMP_FALL = 2'd2
    } ramp_state_e;

    typedef enum logic [1:0] {
        IRQ_LVL_HI = 2'd0,
        IRQ_LVL_LO = 2'd1,
        IRQ_PLS_HI = 2'd2,
        IRQ_PLS_LO = 2'd3
    } irq_form_e;
endpackage

// File: rtl/mute_ramp.sv
module mute_ramp
    import soft_mute_pkg::*;
#(
    parameter int GAIN_W   = 5,
    parameter int STEP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_i,
    input  logic              sb_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              up_done_o,
    output logic              dn_done_o
);
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [GAIN_W-1:0] G_MAX  = '1;
    localparam logic [GAIN_W-1:0] G_MIN  = '0;
    localparam logic [CNT_W-1:0]  C_LAST = CNT_W'(STEP_CYC - 1);

    ramp_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [GAIN_W-1:0] gain_q, gain_d;
    logic [GAIN_W-1:0] target;
    logic              tick;

    assign target = mute_i ? G_MIN : G_MAX;
    assign tick   = (cnt_q == C_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RAMP_HOLD;
            cnt_q   <= '0;
            gain_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gain_q  <= gain_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        gain_d    = gain_q;
        up_done_o = 1'b0;
        dn_done_o = 1'b0;
        if (sb_i) begin
            state_d = RAMP_HOLD;
            cnt_d   = '0;
            gain_d  = target;
        end else begin
            unique case (state_q)
                RAMP_HOLD: begin
                    if (gain_q != target) begin
                        state_d = mute_i ? RAMP_FALL : RAMP_RISE;
                        cnt_d   = '0;
                    end
                end
                RAMP_RISE: begin
                    if (mute_i) begin
                        state_d = RAMP_HOLD;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d  = '0;
                        gain_d = gain_q + 1'b1;
                        if (gain_q == G_MAX - 1'b1) begin
                            state_d   = RAMP_HOLD;
                            up_done_o = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RAMP_FALL: begin
                    if (!mute_i) begin
                        state_d = RAMP_HOLD;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d  = '0;
                        gain_d = gain_q - 1'b1;
                        if (gain_q == G_MIN + 1'b1) begin
                            state_d   = RAMP_HOLD;
                            dn_done_o = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = RAMP_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign gain_o = gain_q;

    // R2: outside standby the code moves by at most one per cycle
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_i |=> ((gain_o == $past(gain_o)) ||
                   ({1'b0, gain_o} == {1'b0, $past(gain_o)} + 1'b1) ||
                   ({1'b0, gain_o} + 1'b1 == {1'b0, $past(gain_o)})));

    // R3: a completion pulse lands on the final code
    p_up_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        up_done_o |=> (gain_o == G_MAX));
    p_dn_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_done_o |=> (gain_o == G_MIN));

    // R6: standby with mute drives the code to zero at once
    p_sb_snaps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_i && mute_i) |=> (gain_o == G_MIN));
endmodule

// File: rtl/jack_sync.sv
module jack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic jack_i,
    output logic edge_o
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], jack_i};
    end

    assign edge_o = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/flag_irq.sv
module flag_irq
    import soft_mute_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              wr_flags_i,
    input  logic              wr_mask_i,
    input  logic              wr_ictl_i,
    input  logic [7:0]        wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] mask_o,
    output logic [1:0]        form_o,
    output logic              irq_o
);
    logic [FLAG_W-1:0] flags_q, mask_q, clr;
    irq_form_e         form_q;
    logic              pulse_q, pending;

    assign clr = wr_flags_i ? wdata_i[FLAG_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '1;
            form_q  <= IRQ_LVL_HI;
            pulse_q <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr) | set_i;
            pulse_q <= |(set_i & ~mask_q);
            if (wr_mask_i) mask_q <= wdata_i[FLAG_W-1:0];
            if (wr_ictl_i) form_q <= irq_form_e'(wdata_i[7:6]);
        end
    end

    assign pending = |(flags_q & ~mask_q);

    always_comb begin
        unique case (form_q)
            IRQ_LVL_HI: irq_o = pending;
            IRQ_LVL_LO: irq_o = ~pending;
            IRQ_PLS_HI: irq_o = pulse_q;
            IRQ_PLS_LO: irq_o = ~pulse_q;
            default:    irq_o = pending;
        endcase
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign form_o  = form_q;

    // R7: a set flag stays set unless a 1 was written to it
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags_q) & ~$past(clr)) & ~flags_q) == '0));

    // R10: a high pulse only follows a new unmasked set event
    p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (form_q == IRQ_PLS_HI && $past(form_q) == IRQ_PLS_HI && irq_o)
            |-> $past(|(set_i & ~mask_q)));
endmodule

// File: rtl/soft_mute_irq.sv
module soft_mute_irq
    import soft_mute_pkg::*;
#(
    parameter int GAIN_W      = 5,
    parameter int STEP_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    input  logic [REG_ADDR_W-1:0] reg_raddr,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  jack_in,
    output logic [GAIN_W-1:0]     dac_gain,
    output logic [GAIN_W-1:0]     hp_gain,
    output logic                  irq
);
    logic dac_mute_q, dac_sb_q, hp_mute_q, hp_sb_q;
    logic dac_up, dac_dn, hp_up, hp_dn, jack_edge;
    logic [FLAG_W-1:0] set_vec, flags, mask;
    logic [1:0]        form;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_mute_q <= 1'b1;
            dac_sb_q   <= 1'b1;
            hp_mute_q  <= 1'b1;
            hp_sb_q    <= 1'b1;
        end else if (reg_wr) begin
            if (reg_addr == ADR_DAC_CTL) begin
                dac_mute_q <= reg_wdata[CTL_MUTE_BIT];
                dac_sb_q   <= reg_wdata[CTL_SB_BIT];
            end
            if (reg_addr == ADR_HP_CTL) begin
                hp_mute_q <= reg_wdata[CTL_MUTE_BIT];
                hp_sb_q   <= reg_wdata[CTL_SB_BIT];
            end
        end
    end

    mute_ramp #(.GAIN_W(GAIN_W), .STEP_CYC(STEP_CYC)) u_dac_ramp (
        .clk(clk), .rst_n(rst_n), .mute_i(dac_mute_q), .sb_i(dac_sb_q),
        .gain_o(dac_gain), .up_done_o(dac_up), .dn_done_o(dac_dn)
    );

    mute_ramp #(.GAIN_W(GAIN_W), .STEP_CYC(STEP_CYC)) u_hp_ramp (
        .clk(clk), .rst_n(rst_n), .mute_i(hp_mute_q), .sb_i(hp_sb_q),
        .gain_o(hp_gain), .up_done_o(hp_up), .dn_done_o(hp_dn)
    );

    jack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_jack (
        .clk(clk), .rst_n(rst_n), .jack_i(jack_in), .edge_o(jack_edge)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FB_JACK]   = jack_edge;
        set_vec[FB_HP_UP]  = hp_up;
        set_vec[FB_HP_DN]  = hp_dn;
        set_vec[FB_DAC_UP] = dac_up;
        set_vec[FB_DAC_DN] = dac_dn;
    end

    flag_irq u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec),
        .wr_flags_i(reg_wr && reg_addr == ADR_FLAGS),
        .wr_mask_i (reg_wr && reg_addr == ADR_MASK),
        .wr_ictl_i (reg_wr && reg_addr == ADR_ICTL),
        .wdata_i(reg_wdata), .flags_o(flags), .mask_o(mask),
        .form_o(form), .irq_o(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            ADR_DAC_CTL: begin
                reg_rdata[CTL_MUTE_BIT] = dac_mute_q;
                reg_rdata[CTL_SB_BIT]   = dac_sb_q;
            end
            ADR_HP_CTL: begin
                reg_rdata[CTL_MUTE_BIT] = hp_mute_q;
                reg_rdata[CTL_SB_BIT]   = hp_sb_q;
            end
            ADR_FLAGS: reg_rdata[FLAG_W-1:0] = flags;
            ADR_MASK:  reg_rdata[FLAG_W-1:0] = mask;
            ADR_ICTL:  reg_rdata[7:6]        = form;
            default:   reg_rdata = '0;
        endcase
    end

    // R8: a synchronised jack edge is recorded in the flag register
    p_jack_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jack_edge |=> flags[FB_JACK]);

    // R7: the short-circuit positions never become set
    p_sc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!flags[FB_SC] && !flags[FB_SC_CLR]));
endmodule

// File: tb/test_soft_mute_irq.sv
module test_soft_mute_irq;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [2:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       jack_in = 1'b0;
    logic [4:0] dac_gain, hp_gain;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [4:0] dac_q[$];
    logic [4:0] hp_q[$];
    logic [4:0] dac_prev = '0;
    logic [4:0] hp_prev = '0;

    always #4 clk = ~clk;

    soft_mute_irq #(.STEP_CYC(STEP)) i_soft_mute_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .jack_in(jack_in), .dac_gain(dac_gain), .hp_gain(hp_gain), .irq(irq)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // scoreboard monitor: every gain change is compared with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (dac_gain != dac_prev) begin
                    if (dac_q.size() == 0) chk(0, "R2", "unexpected dac step", dac_gain, dac_prev);
                    else begin
                        logic [4:0] e;
                        e = dac_q.pop_front();
                        chk(dac_gain == e, "R2", "dac step", dac_gain, e);
                    end
                end
                if (hp_gain != hp_prev) begin
                    if (hp_q.size() == 0) chk(0, "R2", "unexpected hp step", hp_gain, hp_prev);
                    else begin
                        logic [4:0] e;
                        e = hp_q.pop_front();
                        chk(hp_gain == e, "R2", "hp step", hp_gain, e);
                    end
                end
            end
            dac_prev = dac_gain;
            hp_prev  = hp_gain;
        end
    end

    task automatic push_seq(input bit hp, input int from, input int to);
        if (from <= to) begin
            for (int v = from; v <= to; v++) if (hp) hp_q.push_back(5'(v)); else dac_q.push_back(5'(v));
        end else begin
            for (int v = from; v >= to; v--) if (hp) hp_q.push_back(5'(v)); else dac_q.push_back(5'(v));
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_gain(input bit hp, input logic [4:0] v);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((hp ? hp_gain : dac_gain) != v) && n < 3000);
        chk(n < 3000, "R2", "ramp reached target", hp ? hp_gain : dac_gain, v);
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e,
                              input string rq, input string what);
        logic [7:0] d;
        rd(a, d);
        chk(d == e, rq, what, d, e);
    endtask

    task automatic count_irq(input logic lvl, output int cnt);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq == lvl) cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dac_gain == 0, "R1", "dac gain reset", dac_gain, 0);
        chk(hp_gain == 0, "R1", "hp gain reset", hp_gain, 0);
        chk(irq == 0, "R1", "irq reset", irq, 0);
        expect_reg(3'd0, 8'h90, "R1", "dac ctl reset");
        expect_reg(3'd1, 8'h90, "R1", "hp ctl reset");
        expect_reg(3'd2, 8'h00, "R1", "flags reset");
        expect_reg(3'd3, 8'h7F, "R1", "mask reset");
        expect_reg(3'd4, 8'h00, "R1", "ictl reset");

        // leave standby, still muted: no movement
        wr(3'd0, 8'h80);
        wr(3'd3, 8'h00);
        repeat (10) @(negedge clk);
        expect_reg(3'd2, 8'h00, "R6", "no flag leaving standby");

        // R2 R3 DAC ramp up
        push_seq(0, 1, 31);
        wr(3'd0, 8'h00);
        wait_gain(0, 5'd30);
        expect_reg(3'd2, 8'h00, "R3", "up flag not early");
        wait_gain(0, 5'd31);
        expect_reg(3'd2, 8'h02, "R3", "dac up flag on final code");
        chk(irq == 1, "R10", "level high irq", irq, 1);

        // R7 write-one-to-clear
        wr(3'd2, 8'h01);
        expect_reg(3'd2, 8'h02, "R7", "zero bit leaves flag");
        wr(3'd2, 8'h02);
        expect_reg(3'd2, 8'h00, "R7", "one bit clears flag");
        chk(irq == 0, "R7", "irq after clear", irq, 0);

        // R9 mask, R3 DAC ramp down
        wr(3'd3, 8'h01);
        push_seq(0, 30, 0);
        wr(3'd0, 8'h80);
        wait_gain(0, 5'd0);
        expect_reg(3'd2, 8'h01, "R3", "dac down flag");
        chk(irq == 0, "R9", "masked flag keeps irq low", irq, 0);
        wr(3'd3, 8'h00);
        chk(irq == 1, "R9", "unmasked flag drives irq", irq, 1);
        wr(3'd2, 8'h7F);
        expect_reg(3'd2, 8'h00, "R7", "0x7F clears all");

        // R10 active-low level, R5 R4 headphone reversal
        wr(3'd4, 8'h40);
        chk(irq == 1, "R10", "low-level idle", irq, 1);
        push_seq(1, 1, 10);
        push_seq(1, 9, 0);
        wr(3'd1, 8'h00);
        wait_gain(1, 5'd10);
        wr(3'd1, 8'h80);
        wait_gain(1, 5'd0);
        repeat (2 * STEP) @(negedge clk);
        expect_reg(3'd2, 8'h04, "R5", "only hp down flag after reversal");
        chk(irq == 0, "R10", "low-level asserted", irq, 0);
        wr(3'd2, 8'h7F);
        wr(3'd4, 8'h00);

        // R4 headphone up flag
        push_seq(1, 1, 31);
        wr(3'd1, 8'h00);
        wait_gain(1, 5'd31);
        expect_reg(3'd2, 8'h08, "R4", "hp up flag");
        wr(3'd2, 8'h7F);

        // R6 standby snaps, no flag
        dac_q.push_back(5'd31);
        wr(3'd0, 8'h10);
        repeat (3) @(negedge clk);
        chk(dac_gain == 31, "R6", "standby jump up", dac_gain, 31);
        dac_q.push_back(5'd0);
        wr(3'd0, 8'h90);
        repeat (3) @(negedge clk);
        chk(dac_gain == 0, "R6", "standby jump down", dac_gain, 0);
        expect_reg(3'd2, 8'h00, "R6", "no flag in standby");

        // R8 jack edges
        @(negedge clk); jack_in = 1'b1;
        repeat (6) @(negedge clk);
        expect_reg(3'd2, 8'h20, "R8", "jack rising edge");
        wr(3'd2, 8'h20);
        expect_reg(3'd2, 8'h00, "R8", "jack flag cleared");
        @(negedge clk); jack_in = 1'b0;
        repeat (6) @(negedge clk);
        expect_reg(3'd2, 8'h20, "R8", "jack falling edge");
        wr(3'd2, 8'h7F);

        // R10 pulse forms
        wr(3'd4, 8'h80);
        @(negedge clk); jack_in = 1'b1;
        count_irq(1'b1, cnt);
        chk(cnt == 1, "R10", "high pulse width", cnt, 1);
        wr(3'd4, 8'hC0);
        chk(irq == 1, "R10", "low pulse idle", irq, 1);
        @(negedge clk); jack_in = 1'b0;
        count_irq(1'b0, cnt);
        chk(cnt == 1, "R10", "low pulse width", cnt, 1);

        repeat (4) @(negedge clk);
        chk(dac_q.size() == 0, "R2", "dac queue drained", dac_q.size(), 0);
        chk(hp_q.size() == 0, "R2", "hp queue drained", hp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule